// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running calendar held in packed BCD (seconds, minutes, hours, day of month, weekday) and raises an alarm when the calendar reaches a programmed point. Five alarm bytes, one per calendar field, sit in a small byte-wide register file. The top bit of each alarm byte removes that field from the comparison, so an alarm can be set for a given second of every minute or for a given weekday of every week. The calendar counter lives outside the block and is presented on input ports, together with a one-cycle pulse for each new second.

The comparison is made only on the seconds pulse. When every field that takes part equals the calendar, a sticky alarm flag is set in the control byte. The flag stays set until software writes a 0 to it. An active-low interrupt line is driven low while the flag and the interrupt enable bit are both set. Software reaches the alarm bytes, the flag and the enable through one write/read port with a combinational read path.

Top module: `alm_match_top`

## Requirements
- R1: After reset every alarm byte reads 0x80, the control byte at address 0x01 reads 0x00 and irq_no is 1.
- R2: The alarm bytes sit at addresses 0x0A (seconds), 0x0B (minutes), 0x0C (hours), 0x0D (day of month) and 0x0E (weekday); a write stores all 8 bits and a read returns them.
- R3: An alarm byte with bit 7 set excludes its field from the comparison; any calendar value for that field is accepted.
- R4: Only bits 6:0 are compared for seconds and minutes, bits 5:0 for hours and day of month, and bits 2:0 for weekday; other bits of both the calendar input and the alarm byte (bit 7 aside) have no effect.
- R5: The flag (bit 4 of the control byte) is set in the clock edge on which tick_i is 1 and all enabled fields match; without tick_i no match sets it.
- R6: With all five fields disabled the flag never sets.
- R7: The flag is sticky: writing the control byte with bit 4 at 0 clears it, writing bit 4 at 1 leaves it as it was.
- R8: When a match on a tick and a clearing write fall in the same cycle, the flag ends up set.
- R9: Bit 1 of the control byte is the interrupt enable, stored and read back; irq_no is 0 exactly while the flag and the enable are both 1.
- R10: Reads of any other address return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per calendar second |
| sec_i | input | 8 | Calendar seconds, BCD |
| min_i | input | 8 | Calendar minutes, BCD |
| hour_i | input | 8 | Calendar hours, BCD |
| mday_i | input | 8 | Calendar day of month, BCD |
| wday_i | input | 8 | Calendar weekday, binary 0..6 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| irq_no | output | 1 | Alarm interrupt, active low |

## Verification
The bench builds the block with its default parameters: five fields, a 5-bit address, alarm bytes from 0x0A and the control byte at 0x01. With these values the whole register map is reachable, so every field's mask width, each per-field disable and the flag/enable bit positions can be driven through the port. A vector table covers matching, mismatching, partially disabled and fully disabled alarms, plus calendar values with stray upper bits; directed steps cover reset, stickiness, the write-1 case, the set/clear collision and unmapped addresses.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int DW         = 8;
  localparam int DIS_BIT    = DW - 1;

  // significant bits per field: sec, min, hour, mday, wday
  function automatic logic [DW-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      default: return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
  import alm_pkg::*;
#(
  parameter int AW         = 5,
  parameter int ALARM_BASE = 10,
  parameter int CTRL_ADDR  = 1,
  parameter int FLAG_BIT   = 4,
  parameter int IE_BIT     = 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [AW-1:0]                     addr_i,
  input  logic [DW-1:0]                     wdata_i,
  input  logic                              flag_i,
  output logic [NUM_FIELDS-1:0][DW-1:0]     alarm_o,
  output logic                              ie_o,
  output logic                              clr_req_o,
  output logic [DW-1:0]                     rdata_o
);
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

  logic [NUM_FIELDS-1:0][DW-1:0] alarm_q;
  logic                          ie_q;
  logic                          ctrl_wr;

  assign ctrl_wr = wr_en_i && (addr_i == CTRL_A);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alarm
    localparam logic [AW-1:0] MY_A = AW'(ALARM_BASE + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          alarm_q[i] <= 8'h80;
      else if (wr_en_i && addr_i == MY_A)   alarm_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= 1'b0;
    else if (ctrl_wr) ie_q <= wdata_i[IE_BIT];
  end

  assign clr_req_o = ctrl_wr && !wdata_i[FLAG_BIT];
  assign alarm_o   = alarm_q;
  assign ie_o      = ie_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_A) begin
      rdata_o[FLAG_BIT] = flag_i;
      rdata_o[IE_BIT]   = ie_q;
    end
    for (int i = 0; i < NUM_FIELDS; i++)
      if (addr_i == AW'(ALARM_BASE + i)) rdata_o = alarm_q[i];
  end

  assert_alarm_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(alarm_q));
  assert_ie_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ie_q));
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
  import alm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][DW-1:0] alarm_i,
  input  logic [NUM_FIELDS-1:0][DW-1:0] time_i,
  output logic                          hit_o
);
  logic [NUM_FIELDS-1:0] en, eq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    localparam logic [DW-1:0] MASK = field_mask(i);
    assign en[i] = !alarm_i[i][DIS_BIT];
    assign eq[i] = ((alarm_i[i] ^ time_i[i]) & MASK) == '0;
  end

  // a fully disabled alarm must not match every second
  assign hit_o = (|en) && (&(eq | ~en));
endmodule

// File: rtl/alm_flag_ctrl.sv
module alm_flag_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_req_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (tick_i && hit_i)  flag_q <= 1'b1;
    else if (clr_req_i)        flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_flag_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit_i) |=> flag_q);
  assert_flag_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i && hit_i));
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_req_i) |=> flag_q);
endmodule

// File: rtl/alm_match_top.sv
module alm_match_top
  import alm_pkg::*;
#(
  parameter int AW         = 5,
  parameter int ALARM_BASE = 10,
  parameter int CTRL_ADDR  = 1,
  parameter int FLAG_BIT   = 4,
  parameter int IE_BIT     = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] sec_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] hour_i,
  input  logic [DW-1:0] mday_i,
  input  logic [DW-1:0] wday_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_no
);
  logic [NUM_FIELDS-1:0][DW-1:0] alarm, cal;
  logic                          ie, clr_req, hit, flag;
  logic [NUM_FIELDS-1:0]         dis;

  assign cal = {wday_i, mday_i, hour_i, min_i, sec_i};

  alm_regfile #(
    .AW(AW), .ALARM_BASE(ALARM_BASE), .CTRL_ADDR(CTRL_ADDR),
    .FLAG_BIT(FLAG_BIT), .IE_BIT(IE_BIT)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .flag_i(flag), .alarm_o(alarm), .ie_o(ie), .clr_req_o(clr_req),
    .rdata_o
  );

  alm_field_cmp u_cmp (.alarm_i(alarm), .time_i(cal), .hit_o(hit));

  alm_flag_ctrl u_flag (
    .clk_i, .rst_ni, .tick_i, .hit_i(hit), .clr_req_i(clr_req), .flag_o(flag)
  );

  assign irq_no = !(flag && ie);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dis
    assign dis[i] = alarm[i][DIS_BIT];
  end

  assert_no_fire_all_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dis) |-> !hit);
  assert_irq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag |-> irq_no);
  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> irq_no);
endmodule

// File: tb/tb_alm_match_top.sv
module tb_alm_match_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  logic [7:0] tv [5];
  int         n_chk = 0, n_fail = 0;
  logic [7:0] d;

  // {alarm sec,min,hour,mday,wday, time sec,min,hour,mday,wday, expect}
  localparam logic [80:0] VEC [NV] = '{
    {8'h30,8'h15,8'h12,8'h25,8'h03, 8'h30,8'h15,8'h12,8'h25,8'h03, 1'b1},
    {8'h30,8'h15,8'h12,8'h25,8'h03, 8'h31,8'h15,8'h12,8'h25,8'h03, 1'b0},
    {8'hC5,8'h15,8'h12,8'h25,8'h03, 8'h31,8'h15,8'h12,8'h25,8'h03, 1'b1},
    {8'h80,8'h80,8'h80,8'h80,8'h05, 8'h59,8'h00,8'h23,8'h31,8'h05, 1'b1},
    {8'h30,8'h15,8'h12,8'h65,8'h03, 8'h30,8'h15,8'hD2,8'h25,8'h03, 1'b1},
    {8'h30,8'h15,8'h12,8'h25,8'h03, 8'hB0,8'h95,8'h12,8'h25,8'hFB, 1'b1},
    {8'h80,8'h80,8'h80,8'h80,8'h80, 8'h30,8'h15,8'h12,8'h25,8'h03, 1'b0},
    {8'h30,8'h15,8'h12,8'h25,8'h03, 8'h30,8'h55,8'h12,8'h25,8'h03, 1'b0},
    {8'h30,8'h15,8'h12,8'h25,8'h03, 8'h30,8'h15,8'h32,8'h25,8'h03, 1'b0}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  alm_match_top dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .sec_i(tv[0]), .min_i(tv[1]), .hour_i(tv[2]), .mday_i(tv[3]), .wday_i(tv[4]),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) tv[i] = 8'h00;
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rd(5'(10 + i), d);
      check("R1 alarm reset", d, 8'h80);
    end
    rd(5'h01, d);
    check("R1 ctrl reset", d, 8'h00);
    check("R1 irq reset", {7'b0, irq_n}, 8'h01);

    // R6 reset alarms all disabled: ticks with calendar at zero never fire
    pulse_tick();
    rd(5'h01, d);
    check("R6 reset no fire", d, 8'h00);

    // R2 readback of all bits
    for (int i = 0; i < 5; i++) wr(5'(10 + i), 8'h5A ^ 8'(i));
    for (int i = 0; i < 5; i++) begin
      rd(5'(10 + i), d);
      check("R2 readback", d, 8'h5A ^ 8'(i));
    end

    // R10 unmapped addresses
    wr(5'h0F, 8'hFF);
    wr(5'h00, 8'hFF);
    rd(5'h0F, d);
    check("R10 unmapped read", d, 8'h00);
    rd(5'h00, d);
    check("R10 unmapped read", d, 8'h00);
    rd(5'h0E, d);
    check("R10 neighbour intact", d, 8'h5A ^ 8'h04);
    rd(5'h01, d);
    check("R10 ctrl intact", d, 8'h00);

    // vector table: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < 5; f++) wr(5'(10 + f), VEC[v][80 - 8*f -: 8]);
      wr(5'h01, 8'h00);
      @(negedge clk);
      for (int f = 0; f < 5; f++) tv[f] = VEC[v][40 - 8*f -: 8];
      pulse_tick();
      rd(5'h01, d);
      check($sformatf("R3/R4/R5/R6 vector %0d", v), d, VEC[v][0] ? 8'h10 : 8'h00);
    end

    // R5 no tick, no set
    for (int f = 0; f < 5; f++) wr(5'(10 + f), VEC[0][80 - 8*f -: 8]);
    wr(5'h01, 8'h00);
    for (int f = 0; f < 5; f++) tv[f] = VEC[0][40 - 8*f -: 8];
    repeat (3) @(negedge clk);
    rd(5'h01, d);
    check("R5 no tick", d, 8'h00);

    // R9 enable without flag: irq stays high
    wr(5'h01, 8'h02);
    rd(5'h01, d);
    check("R9 ie readback", d, 8'h02);
    check("R9 irq idle", {7'b0, irq_n}, 8'h01);
    pulse_tick();
    rd(5'h01, d);
    check("R5 fire with ie", d, 8'h12);
    check("R9 irq asserted", {7'b0, irq_n}, 8'h00);

    // R7 sticky after time moves away, write 1 keeps it
    tv[0] = 8'h31;
    pulse_tick();
    wr(5'h01, 8'h12);
    rd(5'h01, d);
    check("R7 write one keeps", d, 8'h12);
    wr(5'h01, 8'h10);
    rd(5'h01, d);
    check("R9 ie off keeps flag", d, 8'h10);
    check("R9 irq masked", {7'b0, irq_n}, 8'h01);
    wr(5'h01, 8'h02);
    rd(5'h01, d);
    check("R7 write zero clears", d, 8'h02);
    check("R9 irq released", {7'b0, irq_n}, 8'h01);

    // R8 collision: match tick and clearing write in same cycle
    tv[0] = 8'h30;
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 5'h01; wdata = 8'h02;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(5'h01, d);
    check("R8 set beats clear", d, 8'h12);

    finish_run();
  end
endmodule